// File: doc/BRIEF.md
# Single-Wire Bus Reset and Discovery Sequencer

This block is the master side of bring-up for a single-wire, open-drain bus whose slave draws its power from the line. A one-cycle start pulse runs one full sequence. First the line is held low long enough to reset the slave. The low time is longer when the caller flags the slave as busy, so the slave's stored charge runs out. Next the line is released for a recovery interval. Then a short low pulse asks the slave to acknowledge. The bus is sampled at a fixed offset from the start of that pulse. Finally the block waits until the line has stayed high for a hold interval, after which a command engine may issue its first Start condition.

Every interval is a parameter counted in clock cycles. The block never drives the line high. It only raises a pull-low enable, and the external pull-up gives the high level. The result of each sequence is a one-cycle done pulse and a present flag. A ready-for-start level stays high until the next sequence is accepted. A command engine must see ready high before it sends anything, so discovery always comes before the first command after reset.

Top module: `swd_master`

## Requirements
- R1: After synchronous reset, and whenever reset is applied mid-sequence, pull_low_o, done_o, present_o and ready_o are all 0.
- R2: A start_i pulse seen while idle makes pull_low_o go high from the next cycle. It stays high for exactly T_RESET cycles when slave_busy_i was 0 at that start.
- R3: When slave_busy_i was 1 at the accepted start, the reset low pulse lasts exactly T_DSCHG cycles. slave_busy_i is not looked at during the rest of the sequence.
- R4: After the reset pulse, pull_low_o stays low for exactly T_RRT cycles before the discovery pulse begins.
- R5: The discovery pulse holds pull_low_o high for exactly T_DRR cycles. A sequence produces exactly two low pulses, and pull_low_o is the block's only bus drive.
- R6: The bus is sampled at the clock edge that ends cycle T_MSDR of the discovery phase. The first cycle of the discovery pulse counts as cycle 0. A low level (bus_i = 0) gives present 1 and a high level gives present 0.
- R7: After the sample, the block waits for T_HTSS consecutive cycles with bus_i = 1. Any low cycle restarts that count. The sequence ends on the edge that completes the count.
- R8: done_o is high for exactly one cycle per completed sequence. present_o takes its new value on that same edge and holds it at all other times.
- R9: ready_o is 0 from reset and throughout a sequence. It rises together with done_o and stays high until the next accepted start.
- R10: start_i pulses that arrive while a sequence is running are ignored. The sequence keeps its timing and its two pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request a reset and discovery sequence |
| slave_busy_i | input | 1 | Selects the long discharge reset, sampled at start |
| bus_i | input | 1 | Synchronised level of the bus line |
| pull_low_o | output | 1 | Open-drain enable: 1 pulls the line low |
| done_o | output | 1 | One-cycle pulse when a sequence finishes |
| present_o | output | 1 | 1 when the last discovery saw an acknowledge |
| ready_o | output | 1 | Line held high long enough for a Start condition |

## Verification
The assertions assume that start_i is a synchronous pulse and that bus_i is already synchronised, with the line low whenever pull_low_o is high. The pulse-length property also assumes that no reset cuts a pulse short, except on the cycle right after reset. The bench keeps within these limits by building bus_i as the wired-AND of the block's own pull-low and a slave model. The slave model drives low only from the first cycle of the discovery pulse and only for a chosen acknowledge length. Those lengths straddle the sample offset, so both outcomes of the sample are covered. Long acknowledges also stretch into the hold wait and push back its completion.

// File: rtl/swd_pkg.sv
package swd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET_LOW,
        ST_RECOVER,
        ST_DISCOVER,
        ST_HOLD
    } swd_state_e;

    typedef struct packed {
        logic done;
        logic ready;
    } swd_flags_t;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned width_for(input int unsigned value);
        return (value < 2) ? 1 : $clog2(value + 1);
    endfunction

    function automatic bit timing_ok(input int t_reset, input int t_dschg, input int t_rrt,
                                     input int t_drr, input int t_msdr, input int t_htss);
        return (t_reset >= 1) && (t_dschg >= t_reset) && (t_rrt >= 1) &&
               (t_drr >= 1) && (t_msdr >= t_drr) && (t_htss >= 1);
    endfunction

endpackage

// File: rtl/swd_phase_timer.sv
module swd_phase_timer #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear_i,
    output logic [CNT_W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst || clear_i) begin
            count_o <= '0;
        end else if (count_o != {CNT_W{1'b1}}) begin
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/swd_presence_sampler.sv
module swd_presence_sampler (
    input  logic clk,
    input  logic rst,
    input  logic strobe_i,
    input  logic publish_i,
    input  logic bus_i,
    output logic present_o
);
    logic seen_low_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_low_q <= 1'b0;
            present_o  <= 1'b0;
        end else begin
            if (strobe_i) begin
                seen_low_q <= ~bus_i;
            end
            if (publish_i) begin
                present_o <= seen_low_q;
            end
        end
    end
endmodule

// File: rtl/swd_seq_ctrl.sv
module swd_seq_ctrl
    import swd_pkg::*;
#(
    parameter int unsigned T_RESET = 8,
    parameter int unsigned T_DSCHG = 20,
    parameter int unsigned T_RRT   = 6,
    parameter int unsigned T_DRR   = 3,
    parameter int unsigned T_MSDR  = 5,
    parameter int unsigned T_HTSS  = 4,
    parameter int unsigned CNT_W   = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             busy_i,
    input  logic             bus_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             clear_o,
    output logic             strobe_o,
    output logic             finish_o,
    output logic             pull_low_o,
    output swd_flags_t       flags_o
);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(T_RESET - 1);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(T_DSCHG - 1);
    localparam logic [CNT_W-1:0] LAST_RRT   = CNT_W'(T_RRT - 1);
    localparam logic [CNT_W-1:0] LEN_DRR    = CNT_W'(T_DRR);
    localparam logic [CNT_W-1:0] AT_SAMPLE  = CNT_W'(T_MSDR);
    localparam logic [CNT_W-1:0] LAST_HTSS  = CNT_W'(T_HTSS - 1);

    swd_state_e       state_q, state_d;
    logic             long_q;
    logic [CNT_W-1:0] reset_last;

    assign reset_last = long_q ? LAST_LONG : LAST_SHORT;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (start_i) state_d = ST_RESET_LOW;
            ST_RESET_LOW: if (count_i == reset_last) state_d = ST_RECOVER;
            ST_RECOVER:   if (count_i == LAST_RRT) state_d = ST_DISCOVER;
            ST_DISCOVER:  if (count_i == AT_SAMPLE) state_d = ST_HOLD;
            ST_HOLD:      if (bus_i && count_i == LAST_HTSS) state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    assign clear_o    = (state_d != state_q) || (state_q == ST_HOLD && !bus_i);
    assign strobe_o   = (state_q == ST_DISCOVER) && (count_i == AT_SAMPLE);
    assign finish_o   = (state_q == ST_HOLD) && (state_d == ST_IDLE);
    assign pull_low_o = (state_q == ST_RESET_LOW) ||
                        (state_q == ST_DISCOVER && count_i < LEN_DRR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            long_q  <= 1'b0;
            flags_o <= '0;
        end else begin
            state_q       <= state_d;
            flags_o.done  <= finish_o;
            if (state_q == ST_IDLE && start_i) begin
                long_q        <= busy_i;
                flags_o.ready <= 1'b0;
            end else if (finish_o) begin
                flags_o.ready <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/swd_master.sv
module swd_master
    import swd_pkg::*;
#(
    parameter int unsigned T_RESET = 9600,
    parameter int unsigned T_DSCHG = 15000,
    parameter int unsigned T_RRT   = 800,
    parameter int unsigned T_DRR   = 100,
    parameter int unsigned T_MSDR  = 200,
    parameter int unsigned T_HTSS  = 15000
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic slave_busy_i,
    input  logic bus_i,
    output logic pull_low_o,
    output logic done_o,
    output logic present_o,
    output logic ready_o
);
    localparam int unsigned LONGEST = max2(max2(max2(T_RESET, T_DSCHG), max2(T_RRT, T_MSDR)),
                                           max2(T_DRR, T_HTSS));
    localparam int unsigned CNT_W   = width_for(LONGEST);

    if (!timing_ok(T_RESET, T_DSCHG, T_RRT, T_DRR, T_MSDR, T_HTSS)) begin : g_bad_timing
        $error("swd_master: timing parameters out of range");
    end

    logic [CNT_W-1:0] count;
    logic             clear, strobe, finish;
    swd_flags_t       flags;

    swd_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear),
        .count_o (count)
    );

    swd_seq_ctrl #(
        .T_RESET (T_RESET),
        .T_DSCHG (T_DSCHG),
        .T_RRT   (T_RRT),
        .T_DRR   (T_DRR),
        .T_MSDR  (T_MSDR),
        .T_HTSS  (T_HTSS),
        .CNT_W   (CNT_W)
    ) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .busy_i     (slave_busy_i),
        .bus_i      (bus_i),
        .count_i    (count),
        .clear_o    (clear),
        .strobe_o   (strobe),
        .finish_o   (finish),
        .pull_low_o (pull_low_o),
        .flags_o    (flags)
    );

    swd_presence_sampler u_sampler (
        .clk       (clk),
        .rst       (rst),
        .strobe_i  (strobe),
        .publish_i (finish),
        .bus_i     (bus_i),
        .present_o (present_o)
    );

    assign done_o  = flags.done;
    assign ready_o = flags.ready;
endmodule

// File: rtl/swd_master_chk.sv
module swd_master_chk #(
    parameter int unsigned T_RESET = 8,
    parameter int unsigned T_DSCHG = 20,
    parameter int unsigned T_DRR   = 3
) (
    input logic clk,
    input logic rst,
    input logic start_i,
    input logic pull_low_o,
    input logic done_o,
    input logic present_o,
    input logic ready_o
);
    int unsigned run_len;

    always_ff @(posedge clk) begin
        if (rst)             run_len <= 0;
        else if (pull_low_o) run_len <= run_len + 1;
        else                 run_len <= 0;
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R8
    present_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> present_o == $past(present_o));

    // R9
    ready_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ready_o) |-> done_o);

    // R9
    ready_released_chk: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> !pull_low_o);

    // R2
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (ready_o && start_i) |=> (pull_low_o && !ready_o));

    // R5
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(pull_low_o) && !$past(rst)) |->
            (run_len == T_RESET || run_len == T_DSCHG || run_len == T_DRR));
endmodule

bind swd_master swd_master_chk #(
    .T_RESET (T_RESET),
    .T_DSCHG (T_DSCHG),
    .T_DRR   (T_DRR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_i),
    .pull_low_o (pull_low_o),
    .done_o     (done_o),
    .present_o  (present_o),
    .ready_o    (ready_o)
);

// File: tb/tb_swd_master.sv
`timescale 1ns/1ps
module tb_swd_master;
    localparam int T_RESET = 8;
    localparam int T_DSCHG = 20;
    localparam int T_RRT   = 6;
    localparam int T_DRR   = 3;
    localparam int T_MSDR  = 5;
    localparam int T_HTSS  = 4;
    localparam int T_DACK  = 12;

    localparam int NV = 6;
    localparam int V_BUSY [NV] = '{0, 0, 0, 1, 1, 0};
    localparam int V_ACK  [NV] = '{0, T_MSDR, T_MSDR + 1, T_DACK, 0, T_DACK};
    localparam int V_PRES [NV] = '{0, 0, 1, 1, 0, 1};

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start_i = 1'b0;
    logic slave_busy_i = 1'b0;
    logic slave_drv = 1'b0;
    logic bus_i;
    logic pull_low_o, done_o, present_o, ready_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign bus_i = !(pull_low_o || slave_drv);

    swd_master #(
        .T_RESET (T_RESET), .T_DSCHG (T_DSCHG), .T_RRT (T_RRT),
        .T_DRR   (T_DRR),   .T_MSDR  (T_MSDR),  .T_HTSS (T_HTSS)
    ) dut (
        .clk (clk), .rst (rst), .start_i (start_i), .slave_busy_i (slave_busy_i),
        .bus_i (bus_i), .pull_low_o (pull_low_o), .done_o (done_o),
        .present_o (present_o), .ready_o (ready_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_seq(input int busy, input int ack, input int inj_k,
                           output int k_done, output int rst_len, output int gap_len,
                           output int drr_len, output int rises, output int ready_bad);
        int k = 0;
        int ack_left = 0;
        bit prev_pl = 1'b0;
        k_done = -1; rst_len = 0; gap_len = 0; drr_len = 0; rises = 0; ready_bad = 0;
        @(negedge clk);
        slave_busy_i = busy[0];
        start_i = 1'b1;
        forever begin
            @(negedge clk);
            k++;
            start_i = (inj_k != 0 && k == inj_k);
            if (busy != 0 && k == 2) slave_busy_i = 1'b0;
            if (done_o) begin
                k_done = k;
                break;
            end
            if (ready_o) ready_bad++;
            if (pull_low_o && !prev_pl) begin
                rises++;
                if (rises == 2) ack_left = ack;
            end
            if (pull_low_o) begin
                if (rises == 1) rst_len++;
                else drr_len++;
            end else if (rises == 1) begin
                gap_len++;
            end
            slave_drv = (ack_left > 0);
            if (ack_left > 0) ack_left--;
            prev_pl = pull_low_o;
            if (k > 5000) break;
        end
        slave_drv = 1'b0;
        start_i = 1'b0;
    endtask

    function automatic int exp_done_k(input int busy, input int ack);
        int len = (busy != 0) ? T_DSCHG : T_RESET;
        int late = (ack > T_MSDR + 1) ? ack - T_MSDR - 1 : 0;
        return len + T_RRT + T_MSDR + 1 + late + T_HTSS + 1;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int kd, rl, gl, dl, rs, rb;
        repeat (3) @(negedge clk);
        // R1: outputs after reset
        chk(!pull_low_o && !done_o && !present_o && !ready_o, "R1 reset state",
            {pull_low_o, done_o, present_o, ready_o}, 0);
        rst = 1'b0;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_seq(V_BUSY[v], V_ACK[v], 0, kd, rl, gl, dl, rs, rb);
            if (V_BUSY[v] != 0) chk(rl == T_DSCHG, "R3 discharge low length", rl, T_DSCHG);
            else                chk(rl == T_RESET, "R2 reset low length", rl, T_RESET);
            chk(gl == T_RRT, "R4 recovery gap", gl, T_RRT);
            chk(dl == T_DRR, "R5 discovery pulse length", dl, T_DRR);
            chk(rs == 2, "R5 pulse count", rs, 2);
            chk(kd == exp_done_k(V_BUSY[v], V_ACK[v]), "R7 sequence length",
                kd, exp_done_k(V_BUSY[v], V_ACK[v]));
            chk(present_o == V_PRES[v][0], "R6 presence sample", present_o, V_PRES[v]);
            chk(ready_o && rb == 0, "R9 ready timing", rb, 0);
            @(negedge clk);
            chk(!done_o, "R8 done single cycle", done_o, 0);
        end

        // R10: a start mid-sequence changes nothing
        run_seq(0, T_DACK, 10, kd, rl, gl, dl, rs, rb);
        chk(kd == exp_done_k(0, T_DACK), "R10 ignored start length", kd, exp_done_k(0, T_DACK));
        chk(rs == 2 && rl == T_RESET, "R10 ignored start pulses", rs, 2);

        // R8: present and ready hold while idle
        repeat (6) @(negedge clk);
        chk(present_o && ready_o && !done_o, "R8 idle hold", {present_o, ready_o, done_o}, 6);

        // R1: reset mid-sequence
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        chk(!pull_low_o && !done_o && !present_o && !ready_o, "R1 mid-sequence reset",
            {pull_low_o, done_o, present_o, ready_o}, 0);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!pull_low_o && !ready_o, "R9 not ready after reset", ready_o, 0);

        run_seq(1, T_MSDR + 1, 0, kd, rl, gl, dl, rs, rb);
        chk(rl == T_DSCHG, "R3 after reset", rl, T_DSCHG);
        chk(present_o == 1'b1, "R6 boundary present", present_o, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule